// File: doc/BRIEF.md
# Quad DAC Serial Command Receiver

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter that is programmed over a three-wire serial link plus a separate update strobe. The serial clock, serial data, the latch strobe and the update strobe all arrive asynchronously. They are brought into the system clock domain by flop synchronisers, and all edge detection and state live in that one domain.

Each command is an 11-bit frame sent most significant bit first: a 2-bit channel number, one range bit that selects a gain of x1 or x2, and an 8-bit unsigned code. A bit is taken on every falling edge of the serial clock. When the eleventh bit arrives, the block pulses a frame strobe and presents the decoded fields. A falling edge on the latch strobe then stores that frame's gain and code in the input register of the addressed channel. A falling edge on the update strobe moves all four input registers to the output registers in the same cycle. A latch edge that finds no complete frame waiting writes nothing, raises a one-cycle error pulse and throws the partial frame away.

Top module: `qdac_cmd_rx`

## Requirements
- R1: Synchronous active-high reset clears all input registers, output registers, the decoded frame fields, the bit counter and both strobes to zero.
- R2: A data bit is taken only on a falling edge of `ser_clk`. A rising edge, or a change of `ser_data` while `ser_clk` is steady, takes no bit.
- R3: On the 11th bit of a frame, `frm_valid` is high for exactly one cycle. At that point `frm_addr` holds bits 1 and 2 received, `frm_gain` holds bit 3, and `frm_code` holds bits 4 to 11, with the first received bit most significant.
- R4: After the 11th bit the counter returns to zero, so the next bit starts a new frame. Back-to-back frames with no latch edge between them each give their own `frm_valid` pulse.
- R5: A falling edge on `latch_n`, when a complete frame is waiting and no bit of a later frame has arrived, writes that frame's gain and code into the input register of channel `frm_addr` (0=A, 1=B, 2=C, 3=D). The outputs do not change until an update edge.
- R6: A falling edge on `update_n` copies all four input registers (code and gain) to the outputs in the same cycle. At all other times the outputs hold their values.
- R7: A falling edge on `latch_n`, with a partial frame received or with no complete frame waiting (including a second latch edge after a frame has already been consumed), writes no channel and pulses `frm_error` for one cycle. The bit counter restarts at zero.
- R8: A pin edge driven before rising clock edge N shows at the registered outputs after rising edge N+2. This is the two-flop synchroniser plus one edge-detect register.
- R9: Output packing: channel k's code is in `dac_code[8k+7:8k]` and its gain is in `dac_gain[k]` (1 = x2).
- R10: Rising edges on `latch_n` and `update_n` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock (async, idle high) |
| ser_data | input | 1 | Serial data, MSB first (async) |
| latch_n | input | 1 | Latch strobe, falling edge writes an input register (async, idle high) |
| update_n | input | 1 | Update strobe, falling edge updates all outputs (async, idle high) |
| dac_code | output | 32 | Four output codes, channel k in bits 8k+7:8k |
| dac_gain | output | 4 | Output gain flags, bit k for channel k |
| frm_valid | output | 1 | One-cycle strobe when a frame completes |
| frm_addr | output | 2 | Channel field of the last complete frame |
| frm_gain | output | 1 | Range bit of the last complete frame |
| frm_code | output | 8 | Code field of the last complete frame |
| frm_error | output | 1 | One-cycle strobe on a rejected latch edge |

## Verification
The bench targets the following faults:
- A latch edge that comes after only a few bits of a frame. A design that ignores the bit count would write a shifted, half-old word into some channel.
- A second latch edge with no new frame. A design that keeps the pending flag would write the same frame twice and raise no error.
- Two frames sent back to back with no latch between them. A counter that fails to wrap would never report the second frame.
- The outputs before and after the update edge, to the exact cycle. A design that passes latch writes straight through, updates only the addressed channel, or has the wrong synchroniser depth would show the mismatch on the first frame.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    // Channel and frame geometry
    localparam int CH_N    = 4;
    localparam int CODE_W  = 8;
    localparam int ADDR_W  = $clog2(CH_N);
    localparam int FRAME_W = ADDR_W + 1 + CODE_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    // Positions of the asynchronous inputs inside the synchroniser vector
    localparam int SIG_SCLK = 0;
    localparam int SIG_LTCH = 1;
    localparam int SIG_UPD  = 2;
    localparam int SIG_DATA = 3;
    localparam int CTL_W    = 3;
    localparam int SYNC_W   = 4;

    // Idle levels: strobes and serial clock rest high, data rests low
    localparam logic [SYNC_W-1:0] SYNC_IDLE = 4'b0111;

    // Frame in arrival order: first received bit is the MSB of addr
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              gain;
        logic [CODE_W-1:0] code;
    } cmd_frame_t;

    // Contents of one channel register
    typedef struct packed {
        logic              gain;
        logic [CODE_W-1:0] code;
    } chan_word_t;

    function automatic chan_word_t frame_to_word(input cmd_frame_t f);
        chan_word_t w;
        w.gain = f.gain;
        w.code = f.code;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] last_bit_idx();
        return CNT_W'(FRAME_W - 1);
    endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync
    import qdac_pkg::*;
#(
    parameter int               W       = SYNC_W,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] pipe_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                pipe_q[s] <= RST_VAL;
            end
        end else begin
            pipe_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/qdac_fall_det.sv
module qdac_fall_det
    import qdac_pkg::*;
#(
    parameter int           W       = CTL_W,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= lvl;
        end
    end

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_edge
            assign fall[g] = prev_q[g] & ~lvl[g];
        end
    endgenerate

endmodule

// File: rtl/qdac_frame_asm.sv
module qdac_frame_asm
    import qdac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_evt,
    input  logic       bit_val,
    input  logic       abort,
    output logic       frame_ok,
    output logic       done,
    output cmd_frame_t held
);

    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] sh_q;
    logic [FRAME_W-1:0] sh_nxt;
    logic               pend_q;
    logic               at_last;

    assign sh_nxt   = {sh_q[FRAME_W-2:0], bit_val};
    assign at_last  = (cnt_q == last_bit_idx());
    assign frame_ok = pend_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            pend_q <= 1'b0;
            done   <= 1'b0;
            held   <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                // Latch edge consumes a waiting frame or drops a partial one
                cnt_q  <= '0;
                pend_q <= 1'b0;
            end else if (bit_evt) begin
                sh_q <= sh_nxt;
                if (at_last) begin
                    cnt_q  <= '0;
                    pend_q <= 1'b1;
                    done   <= 1'b1;
                    held   <= cmd_frame_t'(sh_nxt);
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/qdac_latch_bank.sv
module qdac_latch_bank
    import qdac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  chan_word_t               wr_word,
    input  logic                     upd_en,
    output logic [CH_N*CODE_W-1:0]   dac_code,
    output logic [CH_N-1:0]          dac_gain
);

    genvar ch;
    generate
        for (ch = 0; ch < CH_N; ch++) begin : g_chan
            chan_word_t in_q;
            chan_word_t out_q;
            logic       hit;

            assign hit = wr_en && (wr_addr == ADDR_W'(ch));

            always_ff @(posedge clk) begin
                if (rst) begin
                    in_q <= '0;
                end else if (hit) begin
                    in_q <= wr_word;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    out_q <= '0;
                end else if (upd_en) begin
                    out_q <= in_q;
                end
            end

            assign dac_code[ch*CODE_W +: CODE_W] = out_q.code;
            assign dac_gain[ch]                  = out_q.gain;
        end
    endgenerate

endmodule

// File: rtl/qdac_cmd_rx.sv
module qdac_cmd_rx
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ser_clk,
    input  logic                   ser_data,
    input  logic                   latch_n,
    input  logic                   update_n,
    output logic [CH_N*CODE_W-1:0] dac_code,
    output logic [CH_N-1:0]        dac_gain,
    output logic                   frm_valid,
    output logic [ADDR_W-1:0]      frm_addr,
    output logic                   frm_gain,
    output logic [CODE_W-1:0]      frm_code,
    output logic                   frm_error
);

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] sync_lvl;
    logic [CTL_W-1:0]  ctl_fall;
    logic              bit_evt;
    logic              load_evt;
    logic              upd_evt;
    logic              frame_ok;
    logic              wr_en;
    cmd_frame_t        held;

    assign raw_in[SIG_SCLK] = ser_clk;
    assign raw_in[SIG_LTCH] = latch_n;
    assign raw_in[SIG_UPD]  = update_n;
    assign raw_in[SIG_DATA] = ser_data;

    qdac_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_in),
        .dout (sync_lvl)
    );

    qdac_fall_det #(
        .W       (CTL_W),
        .RST_VAL (SYNC_IDLE[CTL_W-1:0])
    ) u_fall (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_lvl[CTL_W-1:0]),
        .fall (ctl_fall)
    );

    assign bit_evt  = ctl_fall[SIG_SCLK];
    assign load_evt = ctl_fall[SIG_LTCH];
    assign upd_evt  = ctl_fall[SIG_UPD];

    qdac_frame_asm u_asm (
        .clk      (clk),
        .rst      (rst),
        .bit_evt  (bit_evt),
        .bit_val  (sync_lvl[SIG_DATA]),
        .abort    (load_evt),
        .frame_ok (frame_ok),
        .done     (frm_valid),
        .held     (held)
    );

    assign frm_addr = held.addr;
    assign frm_gain = held.gain;
    assign frm_code = held.code;
    assign wr_en    = load_evt && frame_ok;

    qdac_latch_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (held.addr),
        .wr_word  (frame_to_word(held)),
        .upd_en   (upd_evt),
        .dac_code (dac_code),
        .dac_gain (dac_gain)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_error <= 1'b0;
        end else begin
            frm_error <= load_evt && !frame_ok;
        end
    end

endmodule

// File: rtl/qdac_cmd_rx_chk.sv
module qdac_cmd_rx_chk
    import qdac_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   bit_evt,
    input logic                   load_evt,
    input logic                   upd_evt,
    input logic                   frm_valid,
    input logic                   frm_error,
    input logic [CH_N*CODE_W-1:0] dac_code,
    input logic [CH_N-1:0]        dac_gain
);

    // R3: frame strobe lasts a single cycle
    a_r3_valid_single: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> !frm_valid);

    // R3: frame strobe follows a captured serial bit
    a_r3_valid_after_bit: assert property (@(posedge clk) disable iff (rst)
        frm_valid |-> $past(bit_evt));

    // R7: error strobe lasts a single cycle
    a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
        frm_error |=> !frm_error);

    // R7: error only comes from a latch edge
    a_r7_err_from_latch: assert property (@(posedge clk) disable iff (rst)
        frm_error |-> $past(load_evt));

    // R7: a rejected latch never coincides with a frame completing
    a_r7_err_not_valid: assert property (@(posedge clk) disable iff (rst)
        frm_error |-> !frm_valid);

    // R6: outputs hold without an update edge
    a_r6_hold_outputs: assert property (@(posedge clk) disable iff (rst)
        !upd_evt |=> ($stable(dac_code) && $stable(dac_gain)));

endmodule

bind qdac_cmd_rx qdac_cmd_rx_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_evt   (bit_evt),
    .load_evt  (load_evt),
    .upd_evt   (upd_evt),
    .frm_valid (frm_valid),
    .frm_error (frm_error),
    .dac_code  (dac_code),
    .dac_gain  (dac_gain)
);

// File: tb/test_qdac_cmd_rx.sv
module test_qdac_cmd_rx;
    import qdac_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b1;
    logic        ser_data = 1'b0;
    logic        latch_n = 1'b1;
    logic        update_n = 1'b1;
    logic [31:0] dac_code;
    logic [3:0]  dac_gain;
    logic        frm_valid;
    logic [1:0]  frm_addr;
    logic        frm_gain;
    logic [7:0]  frm_code;
    logic        frm_error;

    qdac_cmd_rx i_qdac_cmd_rx (
        .clk       (clk),
        .rst       (rst),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .latch_n   (latch_n),
        .update_n  (update_n),
        .dac_code  (dac_code),
        .dac_gain  (dac_gain),
        .frm_valid (frm_valid),
        .frm_addr  (frm_addr),
        .frm_gain  (frm_gain),
        .frm_code  (frm_code),
        .frm_error (frm_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    int n_valid_seen = 0;
    int n_err_seen = 0;
    bit finished = 1'b0;
    bit cmp_en = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit q_sclk[$];
    bit q_data[$];
    bit q_ltch[$];
    bit q_upd[$];
    int m_cnt, m_sh, m_addr, m_gain, m_code;
    bit m_pend, m_valid, m_err;
    int m_lat_code[4], m_lat_gain[4], m_out_code[4], m_out_gain[4];

    always @(posedge clk) begin
        if (rst) begin
            q_sclk.push_back(1'b1); q_data.push_back(1'b0);
            q_ltch.push_back(1'b1); q_upd.push_back(1'b1);
            m_cnt = 0; m_sh = 0; m_addr = 0; m_gain = 0; m_code = 0;
            m_pend = 0; m_valid = 0; m_err = 0;
            for (int k = 0; k < 4; k++) begin
                m_lat_code[k] = 0; m_lat_gain[k] = 0;
                m_out_code[k] = 0; m_out_gain[k] = 0;
            end
        end else begin
            q_sclk.push_back(ser_clk); q_data.push_back(ser_data);
            q_ltch.push_back(latch_n); q_upd.push_back(update_n);
        end
        while (q_sclk.size() > 4) begin
            void'(q_sclk.pop_front()); void'(q_data.pop_front());
            void'(q_ltch.pop_front()); void'(q_upd.pop_front());
        end
        if (!rst && q_sclk.size() == 4) begin
            bit f_sclk, f_ltch, f_upd, d;
            f_sclk = q_sclk[0] && !q_sclk[1];
            f_ltch = q_ltch[0] && !q_ltch[1];
            f_upd  = q_upd[0]  && !q_upd[1];
            d      = q_data[1];
            m_valid = 0;
            m_err   = 0;
            if (f_upd) begin
                for (int k = 0; k < 4; k++) begin
                    m_out_code[k] = m_lat_code[k];
                    m_out_gain[k] = m_lat_gain[k];
                end
            end
            if (f_ltch) begin
                if (m_pend && m_cnt == 0) begin
                    m_lat_code[m_addr] = m_code;
                    m_lat_gain[m_addr] = m_gain;
                end else begin
                    m_err = 1;
                end
                m_cnt  = 0;
                m_pend = 0;
            end else if (f_sclk) begin
                m_sh = ((m_sh << 1) | int'(d)) & 32'h7FF;
                if (m_cnt == 10) begin
                    m_cnt   = 0;
                    m_pend  = 1;
                    m_valid = 1;
                    m_addr  = (m_sh >> 9) & 3;
                    m_gain  = (m_sh >> 8) & 1;
                    m_code  = m_sh & 255;
                end else begin
                    m_cnt++;
                end
            end
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && cmp_en) begin
            for (int k = 0; k < 4; k++) begin
                check(dac_code[k*8 +: 8] == 8'(m_out_code[k]), "R6 R8", "dac_code channel",
                      dac_code[k*8 +: 8], m_out_code[k]);
                check(dac_gain[k] == 1'(m_out_gain[k]), "R6 R8", "dac_gain channel",
                      dac_gain[k], m_out_gain[k]);
            end
            check(frm_valid == m_valid, "R3 R4", "frm_valid", frm_valid, m_valid);
            check(frm_error == m_err, "R7", "frm_error", frm_error, m_err);
            if (m_valid) begin
                check(frm_addr == 2'(m_addr), "R3", "frm_addr", frm_addr, m_addr);
                check(frm_gain == 1'(m_gain), "R3", "frm_gain", frm_gain, m_gain);
                check(frm_code == 8'(m_code), "R3", "frm_code", frm_code, m_code);
            end
        end
        if (!rst && frm_valid) n_valid_seen++;
        if (!rst && frm_error) n_err_seen++;
    end

    // ---------------- stimulus tasks ----------------
    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk);
        ser_data = b;
        wait_neg(HALF_BIT);
        ser_clk = 1'b0;
        wait_neg(HALF_BIT);
        ser_clk = 1'b1;
    endtask

    task automatic send_frame(input int a, input int g, input int c);
        logic [10:0] v;
        v = {2'(a), 1'(g), 8'(c)};
        for (int i = 10; i >= 0; i--) send_bit(v[i]);
        wait_neg(4);
    endtask

    task automatic pulse_latch();
        @(negedge clk); latch_n = 1'b0;
        wait_neg(4);
        latch_n = 1'b1;
        wait_neg(4);
    endtask

    task automatic pulse_update();
        @(negedge clk); update_n = 1'b0;
        wait_neg(4);
        update_n = 1'b1;
        wait_neg(4);
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        int v0, e0, ve;
        wait_neg(5);
        rst = 1'b0;
        wait_neg(2);
        // R1: reset state
        check(dac_code == 32'h0, "R1", "dac_code after reset", dac_code, 0);
        check(dac_gain == 4'h0, "R1", "dac_gain after reset", dac_gain, 0);
        check(frm_valid == 1'b0 && frm_error == 1'b0, "R1", "strobes after reset",
              {frm_valid, frm_error}, 0);
        check({frm_addr, frm_gain, frm_code} == 11'h0, "R1", "frame fields after reset",
              {frm_addr, frm_gain, frm_code}, 0);
        cmp_en = 1'b1;

        // R2 R3 R5: one frame to channel A, no update yet
        v0 = n_valid_seen;
        send_frame(0, 0, 8'h5A);
        check(n_valid_seen == v0 + 1, "R3", "valid pulses for one frame", n_valid_seen - v0, 1);
        check(frm_code == 8'h5A && frm_addr == 2'd0, "R2 R3", "decoded frame",
              {frm_addr, frm_code}, 10'h05A);
        pulse_latch();
        check(dac_code == 32'h0, "R5", "outputs before update", dac_code, 0);

        // R8: exact latency of the update edge
        @(negedge clk); update_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(dac_code == 32'h0, "R8", "output one cycle early", dac_code, 0);
        @(negedge clk);
        check(dac_code == 32'h0000_005A, "R8", "output at latency", dac_code, 32'h5A);
        wait_neg(3);
        update_n = 1'b1;
        wait_neg(6);
        check(dac_code == 32'h0000_005A, "R10", "update rising edge", dac_code, 32'h5A);

        // R9: all four channels, packed outputs
        send_frame(1, 1, 8'hC3); pulse_latch();
        send_frame(2, 0, 8'h01); pulse_latch();
        send_frame(3, 1, 8'hFF); pulse_latch();
        check(dac_code == 32'h0000_005A, "R5", "outputs held before update", dac_code, 32'h5A);
        pulse_update();
        check(dac_code == 32'hFF01_C35A, "R9", "packed codes", dac_code, 32'hFF01C35A);
        check(dac_gain == 4'b1010, "R9", "packed gains", dac_gain, 4'b1010);

        // R7: partial frame then latch
        e0 = n_err_seen;
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        wait_neg(4);
        pulse_latch();
        check(n_err_seen == e0 + 1, "R7", "error on partial frame", n_err_seen - e0, 1);
        pulse_update();
        check(dac_code == 32'hFF01_C35A, "R7", "no write on partial frame", dac_code, 32'hFF01C35A);
        send_frame(0, 1, 8'h11); pulse_latch(); pulse_update();
        check(dac_code == 32'hFF01_C311 && dac_gain == 4'b1011, "R7",
              "clean frame after discard", dac_code, 32'hFF01C311);

        // R7: latch with nothing pending
        e0 = n_err_seen;
        pulse_latch();
        check(n_err_seen == e0 + 1, "R7", "error on empty latch", n_err_seen - e0, 1);

        // R4: back-to-back frames, last one wins
        v0 = n_valid_seen;
        send_frame(2, 1, 8'h77);
        send_frame(1, 0, 8'h22);
        check(n_valid_seen == v0 + 2, "R4", "two back-to-back frames", n_valid_seen - v0, 2);
        pulse_latch(); pulse_update();
        check(dac_code == 32'hFF01_2211 && dac_gain == 4'b1001, "R4",
              "second frame latched", dac_code, 32'hFF012211);

        // R2 R10: data toggling while ser_clk high, latch_n rising only
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); ser_data = ~ser_data;
        end
        ser_data = 1'b0;
        v0 = n_valid_seen;
        send_frame(3, 0, 8'h3C);
        check(n_valid_seen == v0 + 1 && frm_code == 8'h3C, "R2", "no stray bits",
              frm_code, 8'h3C);

        // Random traffic against the model
        ve = n_errors;
        for (int n = 0; n < 24; n++) begin
            send_frame(int'($urandom_range(3)), int'($urandom_range(1)), int'($urandom_range(255)));
            if ($urandom_range(3) != 0) pulse_latch();
            if (n % 3 == 2) pulse_update();
        end
        check(n_errors == ve, "R5 R6", "random traffic", n_errors - ve, 0);

        wait_neg(10);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule